// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Deserializer

This block takes a three-wire serial audio stream and turns it into parallel left and right samples for a downstream audio transmitter. The three wires are a bit clock, a frame sync and serial data. It runs on a fast system clock. The bit clock, frame sync and data are brought into that clock domain through a synchronizer. Each rising bit-clock edge is handled as one bit slot.

Three justification modes are supported: left-justified, I2S and right-justified. The word width can be 16, 18, 20 or 24 bits. In each mode the frame sync level maps to a channel in its own way, and the first data bit sits at its own slot after the frame sync edge.

A change of frame sync level restarts the slot count. It also latches the mode and width for the word that follows. Each completed word is sign-extended to 24 bits. It is then presented on registered outputs with a channel flag and a valid strobe one system clock long.

Top module: `sdi_deser`

## Requirements
- R1: `fmt_sel` and `wlen_sel` are latched only at a frame sync edge. A change in the middle of a channel does not alter the word in progress. The new setting governs the word that starts at the next edge.
- R2: Serial data is taken on the rising edge of `bclk_in`, most significant bit first.
- R3: In left-justified mode (`fmt_sel` = 0), the MSB is in slot 0, which is the bit sampled on the same rising edge that sees the new frame sync level. Frame sync high is the left channel and low is the right channel.
- R4: In I2S mode (`fmt_sel` = 1), the MSB is in slot 1. Frame sync low is the left channel and high is the right channel.
- R5: In right-justified mode (`fmt_sel` = 2), the MSB is in slot 32 minus the width: slot 8, 12, 14 or 16 for 24, 20, 18 or 16 bits. The LSB is therefore in slot 31. Frame sync high is the left channel.
- R6: `pcm_data` carries the captured word sign-extended from its configured width to 24 bits. `wlen_sel` codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits.
- R7: Each completed word gives exactly one `pcm_valid` pulse, one system clock long. `pcm_right` is 1 for the right channel. Bits after the LSB and before the next frame sync edge are ignored.
- R8: A frame sync edge restarts the slot count at 0. A word that is cut short by such an edge is dropped and produces no pulse.
- R9: After reset, all outputs are 0. Nothing is captured until the first frame sync edge has been seen.
- R10: The reserved `fmt_sel` code 3 behaves as left-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| fsync_in | input | 1 | Frame sync / channel select |
| sdata_in | input | 1 | Serial data |
| fmt_sel | input | 2 | Justification: 0 left, 1 I2S, 2 right, 3 as left |
| wlen_sel | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 bits |
| pcm_data | output | 24 | Sign-extended sample |
| pcm_right | output | 1 | 1 when the sample belongs to the right channel |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The frame sync edge restarts the slot count and latches the configuration. In left-justified mode that same rising bit-clock edge also captures the MSB, so the restart and the first shift fall on one tick. The vector table drives left-justified frames with 16- and 24-bit words. There the first bit must enter a shifter that is being cleared on the same cycle, and any wrong value ends up in the top bits of the sign-extended result that is compared. A second pair of events also collides: a configuration write lands in the middle of a 24-bit word, and its own edge then arrives. The bench judges this pair by checking that the first word keeps 24 bits and the next one uses the new width.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  localparam int WORD_MAX = 24;

  typedef enum logic [1:0] {
    JUST_LEFT  = 2'd0,
    JUST_I2S   = 2'd1,
    JUST_RIGHT = 2'd2,
    JUST_RSVD  = 2'd3
  } just_e;

  // number of data bits carried for a width code
  function automatic int word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // slot index of the MSB after a frame sync edge
  function automatic int first_slot(input logic [1:0] mode, input logic [1:0] code,
                                    input int slots);
    case (just_e'(mode))
      JUST_I2S:   return 1;
      JUST_RIGHT: return slots - word_bits(code);
      default:    return 0;
    endcase
  endfunction

  // channel owning the half-frame for a given frame sync level
  function automatic logic chan_is_right(input logic [1:0] mode, input logic fs);
    return (just_e'(mode) == JUST_I2S) ? fs : ~fs;
  endfunction

endpackage

// File: rtl/sdi_pin_sync.sv
module sdi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic sd_i,
  output logic tick,
  output logic fs_bit,
  output logic sd_bit,
  output logic fs_edge
);

  // bit 2: bit clock, bit 1: frame sync, bit 0: data
  logic [STAGES-1:0][2:0] pipe;
  logic                   bclk_last;
  logic                   fs_prev;
  logic                   have_prev;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= {bclk_i, fs_i, sd_i};
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign tick    = pipe[STAGES-1][2] & ~bclk_last;
  assign fs_bit  = pipe[STAGES-1][1];
  assign sd_bit  = pipe[STAGES-1][0];
  assign fs_edge = tick & have_prev & (fs_bit != fs_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_last <= 1'b0;
      fs_prev   <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      bclk_last <= pipe[STAGES-1][2];
      if (tick) begin
        fs_prev   <= fs_bit;
        have_prev <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdi_slot_ctrl.sv
module sdi_slot_ctrl
  import sdi_pkg::*;
#(
  parameter int SLOTS_PER_CH = 32,
  parameter int SLOT_W       = $clog2(2 * SLOTS_PER_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fs_edge,
  input  logic              fs_bit,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        wlen_sel,
  output logic              cap_en,
  output logic              cap_clear,
  output logic              cap_last,
  output logic              cap_right,
  output logic [1:0]        cap_wcode,
  output logic [SLOT_W-1:0] slot_q,
  output logic [1:0]        mode_q,
  output logic [1:0]        wcode_q
);

  logic              armed_q;
  logic              right_q;
  logic [SLOT_W-1:0] slot_now;
  logic [1:0]        mode_eff;
  logic [SLOT_W-1:0] msb_slot;
  logic [SLOT_W-1:0] lsb_slot;
  logic              active;

  always_comb begin
    mode_eff  = fs_edge ? fmt_sel  : mode_q;
    cap_wcode = fs_edge ? wlen_sel : wcode_q;
    cap_right = fs_edge ? chan_is_right(fmt_sel, fs_bit) : right_q;
    slot_now  = fs_edge ? '0 : slot_q;
    msb_slot  = SLOT_W'(first_slot(mode_eff, cap_wcode, SLOTS_PER_CH));
    lsb_slot  = SLOT_W'(first_slot(mode_eff, cap_wcode, SLOTS_PER_CH)
                        + word_bits(cap_wcode) - 1);
    active    = fs_edge | armed_q;
    cap_en    = tick & active & (slot_now >= msb_slot) & (slot_now <= lsb_slot);
    cap_last  = cap_en & (slot_now == lsb_slot);
    cap_clear = fs_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      right_q <= 1'b0;
      slot_q  <= '0;
      mode_q  <= '0;
      wcode_q <= '0;
    end else if (fs_edge) begin
      armed_q <= 1'b1;
      right_q <= chan_is_right(fmt_sel, fs_bit);
      slot_q  <= SLOT_W'(1);
      mode_q  <= fmt_sel;
      wcode_q <= wlen_sel;
    end else if (tick && (slot_q != '1)) begin
      slot_q  <= slot_q + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/sdi_word_shift.sv
module sdi_word_shift
  import sdi_pkg::*;
#(
  parameter int OUT_W = WORD_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             cap_clear,
  input  logic             cap_last,
  input  logic             cap_right,
  input  logic [1:0]       cap_wcode,
  input  logic             sd_bit,
  output logic [OUT_W-1:0] pcm_data,
  output logic             pcm_right,
  output logic             pcm_valid
);

  logic [OUT_W-1:0] sh_q;
  logic [OUT_W-1:0] sh_next;
  logic [OUT_W-1:0] ext;
  int               nb;

  always_comb begin
    sh_next = cap_clear ? {{(OUT_W-1){1'b0}}, sd_bit} : {sh_q[OUT_W-2:0], sd_bit};
    nb      = word_bits(cap_wcode);
    for (int i = 0; i < OUT_W; i++) begin
      ext[i] = (i < nb) ? sh_next[i] : sh_next[nb-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      pcm_data  <= '0;
      pcm_right <= 1'b0;
      pcm_valid <= 1'b0;
    end else begin
      pcm_valid <= 1'b0;
      if (cap_en)         sh_q <= sh_next;
      else if (cap_clear) sh_q <= '0;
      if (cap_last) begin
        pcm_data  <= ext;
        pcm_right <= cap_right;
        pcm_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdi_deser.sv
module sdi_deser
  import sdi_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SLOTS_PER_CH = 32,
  parameter int OUT_W        = WORD_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_in,
  input  logic             fsync_in,
  input  logic             sdata_in,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       wlen_sel,
  output logic [OUT_W-1:0] pcm_data,
  output logic             pcm_right,
  output logic             pcm_valid
);

  localparam int SLOT_W = $clog2(2 * SLOTS_PER_CH);

  logic              tick;
  logic              fs_bit;
  logic              sd_bit;
  logic              fs_edge;
  logic              cap_en;
  logic              cap_clear;
  logic              cap_last;
  logic              cap_right;
  logic [1:0]        cap_wcode;
  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        mode_q;
  logic [1:0]        wcode_q;

  sdi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .bclk_i  (bclk_in),
    .fs_i    (fsync_in),
    .sd_i    (sdata_in),
    .tick    (tick),
    .fs_bit  (fs_bit),
    .sd_bit  (sd_bit),
    .fs_edge (fs_edge)
  );

  sdi_slot_ctrl #(.SLOTS_PER_CH(SLOTS_PER_CH), .SLOT_W(SLOT_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .fs_edge   (fs_edge),
    .fs_bit    (fs_bit),
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .cap_en    (cap_en),
    .cap_clear (cap_clear),
    .cap_last  (cap_last),
    .cap_right (cap_right),
    .cap_wcode (cap_wcode),
    .slot_q    (slot_q),
    .mode_q    (mode_q),
    .wcode_q   (wcode_q)
  );

  sdi_word_shift #(.OUT_W(OUT_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .cap_clear (cap_clear),
    .cap_last  (cap_last),
    .cap_right (cap_right),
    .cap_wcode (cap_wcode),
    .sd_bit    (sd_bit),
    .pcm_data  (pcm_data),
    .pcm_right (pcm_right),
    .pcm_valid (pcm_valid)
  );

endmodule

// File: rtl/sdi_deser_chk.sv
module sdi_deser_chk
  import sdi_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int OUT_W  = WORD_MAX
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              fs_edge,
  input logic [SLOT_W-1:0] slot_q,
  input logic [1:0]        mode_q,
  input logic [1:0]        wcode_q,
  input logic [OUT_W-1:0]  pcm_data,
  input logic              pcm_valid
);

  logic ext_ok;
  int   nb;

  always_comb begin
    nb     = word_bits(wcode_q);
    ext_ok = 1'b1;
    for (int i = 0; i < OUT_W; i++) begin
      if (i >= nb && pcm_data[i] != pcm_data[nb-1]) ext_ok = 1'b0;
    end
  end

  // R7: strobe lasts a single cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |=> !pcm_valid);

  // R7: strobe only follows a sampled bit-clock rise
  a_r7_after_tick: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |-> $past(tick));

  // R8: frame sync edge restarts the slot count
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    fs_edge |=> (slot_q == SLOT_W'(1)));

  // R1: configuration held between frame sync edges
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !fs_edge |=> ($stable(mode_q) && $stable(wcode_q)));

  // R6: upper bits replicate the sign bit of the active width
  a_r6_sign_ext: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |-> ext_ok);

  // R9: outputs quiet on the first cycle after reset
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pcm_valid && pcm_data == '0));

endmodule

bind sdi_deser sdi_deser_chk #(.SLOT_W(SLOT_W), .OUT_W(OUT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .fs_edge   (fs_edge),
  .slot_q    (slot_q),
  .mode_q    (mode_q),
  .wcode_q   (wcode_q),
  .pcm_data  (pcm_data),
  .pcm_valid (pcm_valid)
);

// File: tb/test_sdi_deser.sv
`timescale 1ns/1ps
module test_sdi_deser;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_in = 1'b0;
  logic        fsync_in = 1'b1;
  logic        sdata_in = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [1:0]  wlen_sel = 2'd0;
  logic [23:0] pcm_data;
  logic        pcm_right;
  logic        pcm_valid;

  always #10 clk = ~clk;

  sdi_deser i_sdi_deser (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in),
    .sdata_in(sdata_in), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .pcm_data(pcm_data), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
  );

  // {mode, width code, left value, right value}
  localparam logic [51:0] VEC [0:7] = '{
    {2'd0, 2'd0, 24'h001234, 24'h00F00D},
    {2'd3, 2'd3, 24'h7ABCDE, 24'h812345},
    {2'd1, 2'd0, 24'h00ABCD, 24'h005A5A},
    {2'd1, 2'd2, 24'h08765F, 24'h012345},
    {2'd2, 2'd3, 24'hC0FFEE, 24'h3579BD},
    {2'd2, 2'd0, 24'h008001, 24'h007FFF},
    {2'd2, 2'd1, 24'h020001, 24'h01FFFF},
    {2'd2, 2'd2, 24'h080000, 24'h07FFFF}
  };

  int          n_vec = 0;
  int          n_bad = 0;
  int          n_cap = 0;
  int          n_exp = 0;
  logic [24:0] cap_v [0:63];
  logic [24:0] exp_v [0:63];
  string       exp_t [0:63];
  logic        fs_level = 1'b1;
  bit          finished = 1'b0;

  always @(negedge clk) begin
    if (!rst && pcm_valid) begin
      if (n_cap < 64) cap_v[n_cap] = {pcm_right, pcm_data};
      n_cap++;
    end
  end

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 18 : (c == 2'd2) ? 20 : 24;
  endfunction

  function automatic int msb_at(input logic [1:0] m, input logic [1:0] c);
    return (m == 2'd1) ? 1 : (m == 2'd2) ? 32 - wbits(c) : 0;
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] v, input int w);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one_slot(input logic f, input logic d);
    @(negedge clk);
    bclk_in  = 1'b0;
    fsync_in = f;
    sdata_in = d;
    @(negedge clk);
    @(negedge clk);
    bclk_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_chan(input logic lvl, input logic [1:0] m, input logic [1:0] c,
                           input logic [23:0] v, input int nslots, input int chg_at,
                           input logic [1:0] chg_m, input logic [1:0] chg_c);
    int w = wbits(c);
    int o = msb_at(m, c);
    for (int s = 0; s < nslots; s++) begin
      logic b;
      if (s == chg_at) begin
        fmt_sel  = chg_m;
        wlen_sel = chg_c;
      end
      b = (s >= o && s < o + w) ? v[w-1-(s-o)] : ~s[0];
      one_slot(lvl, b);
    end
    fs_level = lvl;
  endtask

  task automatic expect_word(input logic [23:0] v, input logic [1:0] c,
                             input logic right, input string tag);
    exp_v[n_exp] = {right, sext(v, wbits(c))};
    exp_t[n_exp] = tag;
    n_exp++;
  endtask

  task automatic play(input logic [1:0] m, input logic [1:0] c,
                      input logic [23:0] lv, input logic [23:0] rv);
    logic  left_lvl = (m == 2'd1) ? 1'b0 : 1'b1;
    string tag = (m == 2'd1) ? "R4 R6" : (m == 2'd2) ? "R5 R6" :
                 (m == 2'd3) ? "R10 R6" : "R3 R6";
    @(negedge clk);
    fmt_sel  = m;
    wlen_sel = c;
    if (fs_level == left_lvl) send_chan(~left_lvl, m, c, 24'h0, 4, -1, m, c);
    send_chan(left_lvl, m, c, lv, 32, -1, m, c);
    expect_word(lv, c, 1'b0, tag);
    send_chan(~left_lvl, m, c, rv, 32, -1, m, c);
    expect_word(rv, c, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(pcm_valid == 1'b0, "R9 valid", 32'(pcm_valid), 32'd0);
    check(pcm_data == 24'd0, "R9 data", 32'(pcm_data), 32'd0);
    check(pcm_right == 1'b0, "R9 right", 32'(pcm_right), 32'd0);

    // R9: no capture while frame sync has never changed
    send_chan(1'b1, 2'd0, 2'd0, 24'h00FFFF, 40, -1, 2'd0, 2'd0);
    repeat (8) @(negedge clk);
    check(n_cap == 0, "R9 no edge yet", 32'(n_cap), 32'd0);

    // R8: channels cut short by frame sync edges yield nothing
    send_chan(1'b0, 2'd0, 2'd0, 24'h00AAAA, 10, -1, 2'd0, 2'd0);
    send_chan(1'b1, 2'd0, 2'd0, 24'h005555, 12, -1, 2'd0, 2'd0);
    send_chan(1'b0, 2'd0, 2'd3, 24'h123456, 3, -1, 2'd0, 2'd0);
    repeat (8) @(negedge clk);
    check(n_cap == 0, "R8 partial dropped", 32'(n_cap), 32'd0);

    // main table: every mode and width (R2, R3, R4, R5, R6, R7, R10)
    for (int k = 0; k < 8; k++) begin
      play(VEC[k][51:50], VEC[k][49:48], VEC[k][47:24], VEC[k][23:0]);
    end

    // R1: change in mid-word, new setting applies at the next edge
    @(negedge clk);
    fmt_sel  = 2'd0;
    wlen_sel = 2'd3;
    send_chan(1'b1, 2'd0, 2'd3, 24'h9ABCDE, 32, 5, 2'd0, 2'd0);
    expect_word(24'h9ABCDE, 2'd3, 1'b0, "R1 held");
    send_chan(1'b0, 2'd0, 2'd0, 24'h00C3A5, 32, -1, 2'd0, 2'd0);
    expect_word(24'h00C3A5, 2'd0, 1'b1, "R1 applied");

    repeat (12) @(negedge clk);
    // R7: one pulse per word, trailing bits ignored
    check(n_cap == n_exp, "R7 pulse count", 32'(n_cap), 32'(n_exp));
    for (int i = 0; i < n_exp && i < 64; i++) begin
      if (i < n_cap) check(cap_v[i] == exp_v[i], exp_t[i], 32'(cap_v[i]), 32'(exp_v[i]));
      else           check(1'b0, exp_t[i], 32'd0, 32'(exp_v[i]));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule